// File: doc/BRIEF.md
# Display Controller Configuration and Interrupt Registers

This block is the register core of a display controller. A host reaches it over a simple 32-bit register bus that accepts only full, aligned word accesses. It holds the global control word, a configuration word, background and transparency colours for the two outputs (a panel output and a digital output), timing words, per-output panel sizes, and the complete graphics-layer setup. It also keeps an interrupt status and enable pair that drives one interrupt line.

Most of the display-shaping fields are double-buffered. Software writes pending copies. For each output, software then sets that output's commit request bit in the control word. The request stays visible as 1 until the next frame-boundary pulse of that output. On that pulse, hardware copies the output's pending group into its active group and clears the request bit. The active copies can be read back through a read-only mirror window at offset 0x100 above each register. The output enables and the remote-framebuffer mode bit act at once. The graphics-layer enable output follows the active copy of the layer attributes.

Top module: `disp_cfg_regs`

## Requirements
- R1: An access with `byte_en` other than 4'hF, with `addr[1:0]` nonzero, or to an undefined offset (0x07C, or any offset at or above 0x200) changes no state on write and returns 0 on read.
- R2: Constant registers read fixed values: 0x000 reads 0x20, 0x008 reads 1, 0x030 reads 0x7FF and 0x068 reads 256. The video-plane window 0x080 to 0x0FC reads 0 and ignores writes.
- R3: After reset, the capability word (0x01C) reads 0x161 and the row and pixel increments (0x06C, 0x070) read 1. Every other stored register, including the minus-one coded sizes (0x048 digital, 0x04C panel, 0x05C layer), reads 0, and `irq`, `lcd_en`, `dig_en`, `rfb_mode` and `gfx_en` are low.
- R4: Writes keep only the bits of each register's mask:
  - sysconfig 0x004: 0x301B
  - interrupt enable 0x010: 0xFFFF
  - config 0x018: 0x3FFF
  - capability 0x01C: 0x3FF
  - colours 0x020 to 0x02C: 0xFFFFFF
  - line number 0x034: 0x7FF
  - timing 0x038 and 0x03C: 0x0FF0FF3F
  - polarity 0x040: 0x3FFFF
  - divisor 0x044: 0x00FF00FF
  - sizes 0x048, 0x04C, 0x05C and position 0x058 (X in bits 10:0, Y in bits 26:16): 0x07FF07FF
  - layer attributes 0x060: 0x7FF
  - FIFO threshold 0x064: 0x01FF01FF
  - 0x050, 0x054, 0x06C, 0x070, 0x074 and 0x078: all 32 bits
- R5: An `evt` bit sets the matching status bit at 0x00C. Writing 1 to a status bit clears it. An event wins over a clear in the same cycle. The enable register 0x010 keeps 16 bits, and `irq` is high exactly while the status AND the enable is nonzero.
- R6: The control word 0x014 keeps the bits of mask 0x07FF9FFF. Bit 0 drives `lcd_en`, bit 1 drives `dig_en` and bit 11 drives `rfb_mode`, each from the cycle after the write.
- R7: Writing 1 to control bit 5 posts a panel commit request. The bit reads 1 until the next `frame_lcd` pulse. On that pulse the pending panel group is copied to its active copies and the bit clears. Writing 0 does not withdraw a posted request. The panel group is config, panel-side background and transparency (0x020, 0x028), both timing words, polarity, divisor, panel size and all graphics-layer registers 0x050 to 0x078.
- R8: Control bit 6 is the digital commit request. It behaves like bit 5 but uses `frame_dig`, and it copies the digital group: digital background 0x024, digital transparency 0x02C and digital size 0x048.
- R9: A frame pulse with no posted request, or the other output's frame pulse, leaves the active copies unchanged. Writes to pending registers do not alter active copies.
- R10: Offset 0x100 plus a shadowed register's offset reads that register's active copy. Any other offset in the mirror window reads 0, and writes to the window are ignored.
- R11: Writing sysconfig with bit 1 set returns every register, active copy and status bit to its reset value. Sysconfig then holds the written value under its mask.
- R12: `rvalid` rises exactly one cycle after `rd_en` is asserted, with `rdata` holding the register value as it was when the read was issued.
- R13: `gfx_en` follows bit 0 of the active layer-attribute copy, so it rises only on a panel commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| byte_en | input | 4 | Byte lane enables; only 4'hF is accepted |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| evt | input | EVT_W | Interrupt event pulses |
| frame_lcd | input | 1 | Panel output frame-boundary pulse |
| frame_dig | input | 1 | Digital output frame-boundary pulse |
| lcd_en | output | 1 | Panel output enable |
| dig_en | output | 1 | Digital output enable |
| rfb_mode | output | 1 | Remote-framebuffer mode select |
| gfx_en | output | 1 | Active graphics-layer enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a posted commit request that lives across unrelated events. The bench posts a panel request and first sends a digital frame pulse, which must leave the panel copies untouched. Only then does it send the panel pulse. It also sends a frame pulse with no request posted, and it reads the active copies through the mirror window between every step. The same-cycle race between an interrupt event and its write-one clear is forced by driving both in one cycle. The bench then reads the status back.

// File: rtl/disp_cfg_regs.sv
module disp_cfg_regs #(
  parameter int ADDR_W = 9,
  parameter int EVT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        byte_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rvalid,
  input  logic [EVT_W-1:0]  evt,
  input  logic              frame_lcd,
  input  logic              frame_dig,
  output logic              lcd_en,
  output logic              dig_en,
  output logic              rfb_mode,
  output logic              gfx_en,
  output logic              irq
);
  localparam int NREG = 32;
  localparam int IW   = $clog2(NREG);
  localparam logic [IW-1:0] I_SYSCFG = 5'd1, I_IRQST = 5'd3, I_IRQEN = 5'd4,
                            I_CTRL = 5'd5, I_ATTR = 5'd24;
  localparam int GO_L = 5, GO_D = 6;

  function automatic logic [31:0] wmask(input logic [IW-1:0] i);
    case (i)
      5'd1:  return 32'h0000_301B;
      5'd4:  return 32'h0000_FFFF;
      5'd5:  return 32'h07FF_9FFF;
      5'd6:  return 32'h0000_3FFF;
      5'd7:  return 32'h0000_03FF;
      5'd8, 5'd9, 5'd10, 5'd11: return 32'h00FF_FFFF;
      5'd13: return 32'h0000_07FF;
      5'd14, 5'd15: return 32'h0FF0_FF3F;
      5'd16: return 32'h0003_FFFF;
      5'd17: return 32'h00FF_00FF;
      5'd18, 5'd19, 5'd22, 5'd23: return 32'h07FF_07FF;
      5'd24: return 32'h0000_07FF;
      5'd25: return 32'h01FF_01FF;
      5'd20, 5'd21, 5'd27, 5'd28, 5'd29, 5'd30: return 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] rstv(input logic [IW-1:0] i);
    case (i)
      5'd7:         return 32'h161;
      5'd27, 5'd28: return 32'h1;
      default:      return 32'h0;
    endcase
  endfunction

  function automatic logic in_lcd(input logic [IW-1:0] i);
    case (i)
      5'd6, 5'd8, 5'd10, 5'd14, 5'd15, 5'd16, 5'd17, 5'd19,
      5'd20, 5'd21, 5'd22, 5'd23, 5'd24, 5'd25, 5'd27, 5'd28, 5'd29, 5'd30:
        return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic in_dig(input logic [IW-1:0] i);
    return (i == 5'd9) || (i == 5'd11) || (i == 5'd18);
  endfunction

  logic [31:0]      pend [NREG];
  logic [31:0]      act  [NREG];
  logic [EVT_W-1:0] st;
  logic [31:0]      rv;

  wire [IW-1:0] idx    = addr[IW+1:2];
  wire          mirror = addr[8];
  wire          vid    = addr[7];
  wire          ok     = (byte_en == 4'hF) && (addr[1:0] == 2'b00) && ((addr >> 9) == '0);
  wire          plain  = ok && !mirror && !vid;
  wire          wr_reg = wr_en && plain && (wmask(idx) != 32'h0);
  wire          wr_st  = wr_en && plain && (idx == I_IRQST);
  wire          srst   = wr_en && plain && (idx == I_SYSCFG) && wdata[1];
  wire          wr_ctl = wr_reg && (idx == I_CTRL);
  wire          go_l   = pend[I_CTRL][GO_L];
  wire          go_d   = pend[I_CTRL][GO_D];
  wire          cmt_l  = go_l && frame_lcd;
  wire          cmt_d  = go_d && frame_dig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        pend[i] <= rstv(IW'(i));
        act[i]  <= rstv(IW'(i));
      end
      st <= '0;
    end else if (srst) begin
      for (int i = 0; i < NREG; i++) begin
        pend[i] <= rstv(IW'(i));
        act[i]  <= rstv(IW'(i));
      end
      pend[I_SYSCFG] <= wdata & wmask(I_SYSCFG);
      st <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if ((cmt_l && in_lcd(IW'(i))) || (cmt_d && in_dig(IW'(i))))
          act[i] <= pend[i];
      end
      if (wr_reg)
        pend[idx] <= wdata & wmask(idx);
      pend[I_CTRL][GO_L] <= (wr_ctl && wdata[GO_L]) || (go_l && !frame_lcd);
      pend[I_CTRL][GO_D] <= (wr_ctl && wdata[GO_D]) || (go_d && !frame_dig);
      st <= (st & ~(wr_st ? wdata[EVT_W-1:0] : '0)) | evt;
    end
  end

  always_comb begin
    rv = 32'h0;
    if (ok) begin
      if (mirror) begin
        if (!vid && (in_lcd(idx) || in_dig(idx))) rv = act[idx];
      end else if (!vid) begin
        case (idx)
          5'd0:    rv = 32'h20;
          5'd2:    rv = 32'h1;
          5'd3:    rv = 32'(st);
          5'd12:   rv = 32'h7FF;
          5'd26:   rv = 32'd256;
          5'd31:   rv = 32'h0;
          default: rv = pend[idx];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rv;
    end
  end

  assign lcd_en   = pend[I_CTRL][0];
  assign dig_en   = pend[I_CTRL][1];
  assign rfb_mode = pend[I_CTRL][11];
  assign gfx_en   = act[I_ATTR][0];
  assign irq      = |(st & pend[I_IRQEN][EVT_W-1:0]);
endmodule

module disp_cfg_regs_chk #(
  parameter int ADDR_W = 9,
  parameter int EVT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [3:0]        byte_en,
  input logic [31:0]       wdata,
  input logic              rvalid,
  input logic [EVT_W-1:0]  evt,
  input logic              frame_lcd,
  input logic              lcd_en,
  input logic              dig_en,
  input logic              gfx_en,
  input logic              irq
);
  a_r12_rvalid_follows_rd: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  a_r12_no_stray_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(rd_en));
  a_r6_enables_move_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(lcd_en) && $stable(dig_en)) |-> $past(wr_en));
  a_r13_gfx_rises_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gfx_en) |-> $past(frame_lcd));
  a_r5_full_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && byte_en == 4'hF && addr == ADDR_W'('h00C) && (&wdata) && evt == '0) |=> !irq);
  a_r11_soft_reset_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && byte_en == 4'hF && addr == ADDR_W'('h004) && wdata[1])
      |=> (!irq && !lcd_en && !dig_en && !gfx_en));
  a_r1_partial_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && byte_en != 4'hF) |=> ($stable(lcd_en) && $stable(dig_en)));
endmodule

bind disp_cfg_regs disp_cfg_regs_chk #(.ADDR_W(ADDR_W), .EVT_W(EVT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .byte_en(byte_en), .wdata(wdata), .rvalid(rvalid), .evt(evt),
  .frame_lcd(frame_lcd), .lcd_en(lcd_en), .dig_en(dig_en),
  .gfx_en(gfx_en), .irq(irq)
);

// File: tb/tb_disp_cfg_regs.sv
module tb_disp_cfg_regs;
  localparam int AW = 9;
  localparam int EW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0] byte_en = 4'hF;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rvalid;
  logic [EW-1:0] evt = '0;
  logic frame_lcd = 1'b0, frame_dig = 1'b0;
  logic lcd_en, dig_en, rfb_mode, gfx_en, irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  disp_cfg_regs #(.ADDR_W(AW), .EVT_W(EW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .byte_en(byte_en), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .evt(evt), .frame_lcd(frame_lcd), .frame_dig(frame_dig),
    .lcd_en(lcd_en), .dig_en(dig_en), .rfb_mode(rfb_mode),
    .gfx_en(gfx_en), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever read data comes back
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12 unexpected rvalid actual=%h expected=none", rdata);
      end else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    wr_en = 1'b1; addr = a; wdata = d; byte_en = be;
    @(negedge clk);
    wr_en = 1'b0; byte_en = 4'hF;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag,
                    input logic [3:0] be = 4'hF);
    rd_en = 1'b1; addr = a; byte_en = be;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0; byte_en = 4'hF;
  endtask

  task automatic pulse_lcd();
    frame_lcd = 1'b1; @(negedge clk); frame_lcd = 1'b0;
  endtask

  task automatic pulse_dig();
    frame_dig = 1'b1; @(negedge clk); frame_dig = 1'b0;
  endtask

  task automatic event_and_clear(input logic [EW-1:0] e, input logic [31:0] clr);
    evt = e;
    if (clr != 0) begin wr_en = 1'b1; addr = 9'h00C; wdata = clr; end
    @(negedge clk);
    evt = '0; wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reset state
    chk("R3 irq", 32'(irq), 0);
    chk("R3 lcd_en", 32'(lcd_en), 0);
    chk("R3 gfx_en", 32'(gfx_en), 0);
    rd(9'h01C, 32'h161, "R3 capability");
    rd(9'h04C, 32'h0, "R3 panel size");
    rd(9'h06C, 32'h1, "R3 row increment");
    rd(9'h070, 32'h1, "R3 pixel increment");
    // R2 constants
    rd(9'h000, 32'h20, "R2 revision");
    rd(9'h008, 32'h1, "R2 sysstatus");
    rd(9'h030, 32'h7FF, "R2 line status");
    rd(9'h068, 32'd256, "R2 fifo status");
    wr(9'h084, 32'hFFFF_FFFF);
    rd(9'h084, 32'h0, "R2 video plane");

    // R4 masks
    wr(9'h038, 32'hFFFF_FFFF); rd(9'h038, 32'h0FF0_FF3F, "R4 timing");
    wr(9'h01C, 32'hFFFF_FFFF); rd(9'h01C, 32'h3FF, "R4 capability");
    wr(9'h018, 32'hFFFF_FFFF); rd(9'h018, 32'h3FFF, "R4 config");
    wr(9'h020, 32'hFFFF_FFFF); rd(9'h020, 32'hFF_FFFF, "R4 colour");
    wr(9'h044, 32'hFFFF_FFFF); rd(9'h044, 32'h00FF_00FF, "R4 divisor");
    wr(9'h058, 32'hFFFF_FFFF); rd(9'h058, 32'h07FF_07FF, "R4 position");
    wr(9'h060, 32'hFFFF_FFFF); rd(9'h060, 32'h7FF, "R4 attributes");
    wr(9'h010, 32'hFFFF_FFFF); rd(9'h010, 32'hFFFF, "R4 irq enable");

    // R1 rejected accesses
    wr(9'h034, 32'h5, 4'h3);  rd(9'h034, 32'h0, "R1 partial write");
    wr(9'h036, 32'h7);        rd(9'h034, 32'h0, "R1 misaligned write");
    wr(9'h034, 32'hFFFF);     rd(9'h034, 32'h0, "R1 partial read", 4'h1);
    rd(9'h034, 32'h7FF, "R4 line number");
    wr(9'h07C, 32'hFFFF);     rd(9'h07C, 32'h0, "R1 undefined offset");

    // R6 control mask and immediate enables
    wr(9'h014, 32'hFFFF_FFFF);
    chk("R6 lcd_en", 32'(lcd_en), 1);
    chk("R6 dig_en", 32'(dig_en), 1);
    chk("R6 rfb_mode", 32'(rfb_mode), 1);
    rd(9'h014, 32'h07FF_9FFF, "R6 control mask");

    // R11 clean slate
    wr(9'h004, 32'h2);
    chk("R11 lcd_en cleared", 32'(lcd_en), 0);
    rd(9'h004, 32'h2, "R11 sysconfig kept");
    rd(9'h01C, 32'h161, "R11 capability restored");

    // R7 / R9 / R13 panel commit
    wr(9'h04C, 32'h00EF_013F);
    wr(9'h060, 32'h1);
    rd(9'h14C, 32'h0, "R9 pending does not reach active");
    pulse_lcd();
    rd(9'h14C, 32'h0, "R9 frame without request");
    wr(9'h014, 32'h21);
    rd(9'h014, 32'h21, "R7 request visible");
    wr(9'h014, 32'h01);
    rd(9'h014, 32'h21, "R7 zero write keeps request");
    pulse_dig();
    rd(9'h14C, 32'h0, "R9 other output frame");
    chk("R13 gfx_en before commit", 32'(gfx_en), 0);
    pulse_lcd();
    chk("R13 gfx_en after commit", 32'(gfx_en), 1);
    rd(9'h14C, 32'h00EF_013F, "R7 active panel size");
    rd(9'h014, 32'h01, "R7 request cleared");

    // R8 digital commit
    wr(9'h048, 32'h01DF_02CF);
    wr(9'h024, 32'h12_3456);
    wr(9'h04C, 32'h5);
    wr(9'h014, 32'h41);
    pulse_lcd();
    rd(9'h148, 32'h0, "R8 panel frame ignored");
    rd(9'h014, 32'h41, "R8 request pending");
    pulse_dig();
    rd(9'h148, 32'h01DF_02CF, "R8 active digital size");
    rd(9'h124, 32'h12_3456, "R8 active digital colour");
    rd(9'h14C, 32'h00EF_013F, "R8 panel group untouched");
    rd(9'h014, 32'h01, "R8 request cleared");

    // R10 mirror window
    rd(9'h11C, 32'h0, "R10 unshadowed mirror");
    wr(9'h14C, 32'h7);
    rd(9'h14C, 32'h00EF_013F, "R10 mirror write ignored");

    // R5 interrupts
    wr(9'h010, 32'h5);
    event_and_clear(16'h0002, 0);
    chk("R5 masked event", 32'(irq), 0);
    event_and_clear(16'h0001, 0);
    chk("R5 enabled event", 32'(irq), 1);
    wr(9'h00C, 32'h1);
    chk("R5 cleared", 32'(irq), 0);
    rd(9'h00C, 32'h2, "R5 status after clear");
    event_and_clear(16'h0004, 32'h4);
    chk("R5 event wins", 32'(irq), 1);
    rd(9'h00C, 32'h6, "R5 status race");
    wr(9'h00C, 32'hFFFF_FFFF);
    chk("R5 all cleared", 32'(irq), 0);

    // R11 soft reset with live state
    event_and_clear(16'h0001, 0);
    wr(9'h014, 32'h3);
    chk("R11 irq before", 32'(irq), 1);
    wr(9'h004, 32'h3);
    chk("R11 irq", 32'(irq), 0);
    chk("R11 dig_en", 32'(dig_en), 0);
    chk("R11 gfx_en", 32'(gfx_en), 0);
    rd(9'h14C, 32'h0, "R11 active size reset");
    rd(9'h00C, 32'h0, "R11 status reset");
    rd(9'h004, 32'h3, "R11 sysconfig value");

    repeat (3) @(negedge clk);
    chk("R12 all reads returned", 32'(exp_q.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule